// File: doc/BRIEF.md
# Watchdog Timer with Overflow and Reset Pulses

The block is an 8-bit up-counter clocked by a selectable prescaler from the peripheral clock. It is configured through a small register bus. In watchdog mode, software must write the counter back to zero often enough that it never steps from 0xFF to 0x00. If it does step over, the block sets a sticky overflow flag and drives an active-low overflow pulse that board logic can use to reset the system. It can also drive an internal reset pulse of a chosen type.

In interval mode the same counter runs and wraps, but it raises no flag and drives no pulse. A synchronous reset pin clears every register and every pulse. It wins over an overflow that falls in the same cycle.

The register bus is plain control: one write strobe, an address, write data and combinational read data. It has no back-pressure, so every write takes effect on the clock edge where the strobe is high.

Top module: `wdog_core`

## Requirements
- R1: After `rst_n` is released, every register reads zero, `ovf_out_n` is high, and `por_rst_out` and `man_rst_out` are low.
- R2: Register map by `bus_addr`:
  - Address 0 is control: bit 0 is run, bit 1 is watchdog mode, bits 4:2 are the clock select.
  - Address 1 is the 8-bit counter.
  - Address 2 is reset control: bit 0 is the overflow flag, bit 1 is reset enable, bit 2 is reset type.
  - Address 3 reads zero.
  - Written fields read back unchanged.
- R3: While run is 1, the counter rises by one on each prescaler tick. A counter write on the same edge as a tick wins, and no increment or overflow happens on that edge.
- R4: Clock select values 0 to 7 divide the peripheral clock by 1, 64, 128, 256, 512, 1024, 4096 and 16384. The first tick comes in the last cycle of the first full period after run is set.
- R5: In watchdog mode, the step from 0xFF to 0x00 sets the flag. From the next cycle on, it drives the pulses.
- R6: After an overflow, `ovf_out_n` is low for exactly 64 cycles.
- R7: With reset enable at 1, an internal reset pulse starts together with the overflow pulse and lasts 128 cycles. It appears on `por_rst_out` when reset type is 0 and on `man_rst_out` when reset type is 1. With reset enable at 0, neither output moves.
- R8: The flag stays set until software writes 0 to bit 0 of address 2. Writing 1 there has no effect.
- R9: In interval mode (watchdog mode bit 0), the counter wraps from 0xFF to 0x00 with no flag and no pulse.
- R10: `ext_rst_req` high on an edge clears all registers and both pulses. This includes an edge where an overflow would occur: the flag ends at 0 and no pulse starts.
- R11: A new overflow while pulses are active restarts both at their full lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst_req | input | 1 | Synchronous reset pin, active high, has priority |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ovf_out_n | output | 1 | Overflow pulse, active low |
| por_rst_out | output | 1 | Internal power-on reset pulse |
| man_rst_out | output | 1 | Internal manual reset pulse |

## Verification
The bound checker watches the following on every cycle:
- an overflow edge is always followed by a low overflow output and a set flag;
- a low overflow run never exceeds 64 cycles unless a new overflow restarts it;
- the two internal reset outputs are never high together;
- the pin reset always leaves the flag clear and the outputs idle;
- a write of 1 to the flag never sets it;
- a counter write always wins;
- interval mode never sets the flag.

Only the bench scenarios can show the following:
- that the pulses last exactly 64 and 128 cycles and that a restart yields full lengths again;
- that the prescaler divides by the selected ratios;
- that the register layout reads back as specified.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_RCTL = 2'd2;

  // control register field positions
  localparam int CTRL_RUN = 0;
  localparam int CTRL_WDM = 1;
  localparam int CTRL_SEL = 2;

  // reset control field positions
  localparam int RCTL_FLAG = 0;
  localparam int RCTL_REN  = 1;
  localparam int RCTL_TYPE = 2;

  // log2 of the division ratio for each clock select code
  function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 9;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << div_shift(sel)) - 32'd1);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre_q <= '0;
    else if (clr || !run)  pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (clr)            left_q <= '0;
    else if (start)          left_q <= CW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick,
  output logic              run_en,
  output logic              wd_mode,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              rst_en,
  output logic              rst_type,
  output logic              ovf_flag,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_evt,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ctrl, wr_cnt, wr_rctl;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    wr_cnt  = bus_wr && (bus_addr == ADDR_CNT);
    wr_rctl = bus_wr && (bus_addr == ADDR_RCTL);
    ovf_evt = tick && wd_mode && !wr_cnt && !clr && (count == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      wd_mode <= 1'b0;
      clk_sel <= '0;
    end else if (clr) begin
      run_en  <= 1'b0;
      wd_mode <= 1'b0;
      clk_sel <= '0;
    end else if (wr_ctrl) begin
      run_en  <= bus_wdata[CTRL_RUN];
      wd_mode <= bus_wdata[CTRL_WDM];
      clk_sel <= bus_wdata[CTRL_SEL +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en   <= 1'b0;
      rst_type <= 1'b0;
    end else if (clr) begin
      rst_en   <= 1'b0;
      rst_type <= 1'b0;
    end else if (wr_rctl) begin
      rst_en   <= bus_wdata[RCTL_REN];
      rst_type <= bus_wdata[RCTL_TYPE];
    end
  end

  // sticky flag: set wins, software clears only with a 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ovf_flag <= 1'b0;
    else if (clr)                              ovf_flag <= 1'b0;
    else if (ovf_evt)                          ovf_flag <= 1'b1;
    else if (wr_rctl && !bus_wdata[RCTL_FLAG]) ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (wr_cnt) count <= bus_wdata[CNT_W-1:0];
    else if (tick)   count <= count + 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        rdata[CTRL_RUN]           = run_en;
        rdata[CTRL_WDM]           = wd_mode;
        rdata[CTRL_SEL +: SEL_W]  = clk_sel;
      end
      ADDR_CNT:  rdata[CNT_W-1:0] = count;
      ADDR_RCTL: begin
        rdata[RCTL_FLAG] = ovf_flag;
        rdata[RCTL_REN]  = rst_en;
        rdata[RCTL_TYPE] = rst_type;
      end
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int PRE_W   = 14,
  parameter int OVF_LEN = 64,
  parameter int RST_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_out_n,
  output logic              por_rst_out,
  output logic              man_rst_out
);
  localparam int NPULSE = 2;

  logic             run_en, wd_mode, rst_en, rst_type, ovf_flag, ovf_evt, tick;
  logic [SEL_W-1:0] clk_sel;
  logic [CNT_W-1:0] count;
  logic [NPULSE-1:0] pulse_start, pulse_act;
  logic             type_q;

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ext_rst_req),
    .run   (run_en),
    .sel   (clk_sel),
    .tick  (tick)
  );

  wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ext_rst_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick      (tick),
    .run_en    (run_en),
    .wd_mode   (wd_mode),
    .clk_sel   (clk_sel),
    .rst_en    (rst_en),
    .rst_type  (rst_type),
    .ovf_flag  (ovf_flag),
    .count     (count),
    .ovf_evt   (ovf_evt),
    .rdata     (bus_rdata)
  );

  // slot 0: external overflow pulse, slot 1: internal reset pulse
  assign pulse_start = {ovf_evt && rst_en, ovf_evt};

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    wdog_pulse #(.LEN(g == 0 ? OVF_LEN : RST_LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ext_rst_req),
      .start  (pulse_start[g]),
      .active (pulse_act[g])
    );
  end

  // reset type is frozen at the start of each internal pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              type_q <= 1'b0;
    else if (ext_rst_req)    type_q <= 1'b0;
    else if (pulse_start[1]) type_q <= rst_type;
  end

  assign ovf_out_n   = !pulse_act[0];
  assign por_rst_out = pulse_act[1] && !type_q;
  assign man_rst_out = pulse_act[1] &&  type_q;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int OVF_LEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rst_req,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ovf_out_n,
  input logic              por_rst_out,
  input logic              man_rst_out,
  input logic              ovf_flag,
  input logic              wd_mode,
  input logic              ovf_evt,
  input logic [CNT_W-1:0]  count
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_run <= '0;
    else if (ovf_evt || ovf_out_n) low_run <= '0;
    else                          low_run <= low_run + 1'b1;
  end

  // R5 R11
  ovf_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (!ovf_out_n && ovf_flag));

  // R6
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_out_n |-> (low_run < 16'(OVF_LEN)));

  // R7
  one_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(por_rst_out && man_rst_out));

  // R10
  pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> (!ovf_flag && ovf_out_n && !por_rst_out && !man_rst_out));

  // R8
  flag_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && bus_wdata[0] && !ovf_flag && !ovf_evt)
      |=> !ovf_flag);

  // R3
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !ext_rst_req)
      |=> (count == $past(bus_wdata[CNT_W-1:0])));

  // R9
  interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_mode && !ovf_flag) |=> !ovf_flag);
endmodule

bind wdog_core wdog_core_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .OVF_LEN(OVF_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_rst_req (ext_rst_req),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .ovf_out_n   (ovf_out_n),
  .por_rst_out (por_rst_out),
  .man_rst_out (man_rst_out),
  .ovf_flag    (ovf_flag),
  .wd_mode     (wd_mode),
  .ovf_evt     (ovf_evt),
  .count       (count)
);

// File: tb/wdog_core_test.sv
module wdog_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ovf_out_n, por_rst_out, man_rst_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wdog_core uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_req(ext_rst_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_out_n(ovf_out_n),
    .por_rst_out(por_rst_out), .man_rst_out(man_rst_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1 register after reset", v, 0);
    end
    chk(ovf_out_n && !por_rst_out && !man_rst_out, "R1 outputs after reset",
        {ovf_out_n, por_rst_out, man_rst_out}, 3'b100);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(2'd0, 8'h1E);
    rd(2'd0, v); chk(v == 8'h1E, "R2 control readback", v, 8'h1E);
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk(v == 8'h06, "R2 reset control readback", v, 8'h06);
    wr(2'd1, 8'h5A);
    rd(2'd1, v); chk(v == 8'h5A, "R2 counter readback", v, 8'h5A);
    rd(2'd3, v); chk(v == 8'h00, "R2 unused address", v, 0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_div1();
    logic [7:0] v;
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h03);
    step(5);
    rd(2'd1, v); chk(v == 8'hF5, "R3 count by one per tick", v, 8'hF5);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int period);
    logic [7:0] v;
    wr(2'd1, 8'h00);
    wr(2'd0, {3'b000, sel, 2'b11});
    step(period - 1);
    rd(2'd1, v); chk(v == 8'h00, "R4 no tick before period", v, 0);
    step(1);
    rd(2'd1, v); chk(v == 8'h01, "R4 tick at period", v, 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_overflow(input bit ren, input bit typ);
    logic [7:0] v;
    int nlow = 0, npor = 0, nman = 0, first = 0;
    wr(2'd0, 8'h00);
    wr(2'd2, {5'b0, typ, ren, 1'b0});
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h03);
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (!ovf_out_n) begin nlow++; if (first == 0) first = i; end
      if (por_rst_out) npor++;
      if (man_rst_out) nman++;
    end
    wr(2'd0, 8'h00);
    chk(first == 2, "R5 overflow output starts after wrap", first, 2);
    chk(nlow == 64, "R6 overflow pulse length", nlow, 64);
    chk(npor == ((ren && !typ) ? 128 : 0), "R7 power-on reset length", npor,
        (ren && !typ) ? 128 : 0);
    chk(nman == ((ren && typ) ? 128 : 0), "R7 manual reset length", nman,
        (ren && typ) ? 128 : 0);
    rd(2'd2, v); chk(v[0] == 1'b1, "R5 flag set", v[0], 1);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk(v[0] == 1'b1, "R8 write 1 keeps flag", v[0], 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk(v[0] == 1'b0, "R8 write 0 clears flag", v[0], 0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk(v[0] == 1'b0, "R8 write 1 does not set flag", v[0], 0);
  endtask

  task automatic t_interval();
    logic [7:0] v;
    bit low = 1'b0;
    wr(2'd2, 8'h02);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h01);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ovf_out_n || por_rst_out) low = 1'b1;
    end
    rd(2'd1, v); chk(v == 8'h03, "R9 interval wraps", v, 3);
    rd(2'd2, v); chk(v[0] == 1'b0, "R9 interval no flag", v[0], 0);
    chk(!low, "R9 interval no pulse", low, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_write_priority();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h20);
    rd(2'd1, v); chk(v == 8'h20, "R3 write wins over tick", v, 8'h20);
    rd(2'd2, v); chk(v[0] == 1'b0, "R3 no overflow on write edge", v[0], 0);
    chk(ovf_out_n, "R3 no pulse on write edge", ovf_out_n, 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_restart();
    int nlow = 0, npor = 0;
    wr(2'd2, 8'h02);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h03);
    step(1);
    chk(!ovf_out_n, "R11 first overflow", ovf_out_n, 0);
    step(20);
    wr(2'd1, 8'hFF);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!ovf_out_n) nlow++;
      if (por_rst_out) npor++;
    end
    wr(2'd0, 8'h00);
    chk(nlow == 64, "R11 overflow pulse restarted", nlow, 64);
    chk(npor == 128, "R11 reset pulse restarted", npor, 128);
  endtask

  task automatic t_pin();
    logic [7:0] v;
    bit act = 1'b0;
    wr(2'd2, 8'h03);
    rd(2'd2, v); chk(v[0] == 1'b1, "R10 flag set before pin", v[0], 1);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hFF);
    ext_rst_req = 1'b1;
    @(negedge clk);
    ext_rst_req = 1'b0;
    rd(2'd2, v); chk(v == 8'h00, "R10 pin clears flag", v, 0);
    rd(2'd0, v); chk(v == 8'h00, "R10 pin clears control", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R10 pin clears counter", v, 0);
    for (int i = 0; i < 5; i++) begin
      if (!ovf_out_n || por_rst_out || man_rst_out) act = 1'b1;
      @(negedge clk);
    end
    chk(!act, "R10 no pulse after pin", act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_div1();
    t_prescale(3'd1, 64);
    t_prescale(3'd7, 16384);
    t_overflow(1'b1, 1'b0);
    t_overflow(1'b1, 1'b1);
    t_overflow(1'b0, 1'b0);
    t_flag();
    t_interval();
    t_write_priority();
    t_restart();
    t_pin();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule